// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block decides when one DRAM rank must receive a REFRESH command and how long the rank stays unusable after it. It sits beside the command arbiter of a memory controller. A free-running interval timer adds one owed refresh each time it expires. The scheduler asks the arbiter for a slot while refreshes are owed, and after each granted refresh it blocks ACTIVATE and further REFRESH commands for the refresh recovery time. When the case-temperature flag is high, the timer reloads with half the normal interval. A change of the flag is applied only at the next reload, so an interval already running is never cut short.

The arbiter may defer refreshes while it serves other traffic, up to a fixed number of owed refreshes. When that limit is reached, an urgency flag tells the arbiter to give refresh priority. A self-refresh request stops the periodic timer and drops the refreshes still owed, because the device refreshes itself in that mode. Leaving self refresh holds the rank busy for the exit recovery time and starts a fresh interval. All times are counted in controller clocks and set by parameters.

Top module: `refresh_scheduler`

## Requirements
- R1: While and right after synchronous reset, ref_req, ref_urgent and rank_busy are 0 and no refresh is owed.
- R2: With temp_hot low, the first owed refresh appears TREFI_NORM clocks after reset is released (ref_req rises in cycle TREFI_NORM, counting the first cycle out of reset as cycle 0), and the interval between later owed refreshes is also TREFI_NORM clocks.
- R3: The timer samples temp_hot only when it reloads. It uses TREFI_HOT when the flag is 1 and TREFI_NORM when it is 0, so a flag change leaves the interval in progress unchanged.
- R4: ref_req stays 1 while at least one refresh is owed, the rank is in normal operation, and no recovery window is open. A cycle with ref_req and arb_gnt both 1 is a grant. It lowers the owed count by one, and a grant and a timer expiry in the same cycle leave the count unchanged.
- R5: The owed count saturates at MAX_PEND. ref_urgent is 1 exactly when MAX_PEND refreshes are owed, and further timer expiries at that level are dropped.
- R6: rank_busy is 1 for exactly TRFC consecutive cycles starting with the grant cycle. ref_req is 0 during those cycles.
- R7: sr_enter is taken only in normal operation while rank_busy is 0. Once taken, the owed count is cleared, the timer stops, rank_busy stays 1 and ref_req stays 0 until exit. sr_enter in any other cycle has no effect.
- R8: sr_exit is taken only in self refresh. rank_busy then stays 1 for max(5, TRFC + XS_EXTRA) cycles after the exit cycle, and the timer restarts with a full interval in the exit cycle. sr_exit outside self refresh has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_hot | input | 1 | Case temperature above the high threshold |
| arb_gnt | input | 1 | Arbiter issues the requested REFRESH this cycle |
| sr_enter | input | 1 | Request to put the rank into self refresh |
| sr_exit | input | 1 | Request to bring the rank out of self refresh |
| ref_req | output | 1 | A refresh is owed and may be issued now |
| ref_urgent | output | 1 | Owed refreshes have reached the postponement limit |
| rank_busy | output | 1 | ACTIVATE and REFRESH are blocked for the rank |

## Verification
The hardest state to reach from the ports is full saturation while the timer keeps expiring, together with a grant that lands in the same cycle as an expiry. The bench reaches it by holding arb_gnt low for more than MAX_PEND hot intervals, then granting in bursts while the timer runs, with short interval parameters so that saturation comes quickly. Random traffic also issues self-refresh requests in cycles where a recovery window is still open, so the bench can confirm that those requests are dropped.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic {
        RK_RUN  = 1'b0,
        RK_SELF = 1'b1
    } rank_mode_e;

    typedef struct packed {
        logic clear;
        logic tick;
        logic grant;
    } owe_evt_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/refsched_interval_timer.sv
module refsched_interval_timer
    import refsched_pkg::*;
#(
    parameter int unsigned IV_NORM = 6240,
    parameter int unsigned IV_HOT  = 3120
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic hot,
    output logic tick
);
    localparam int unsigned W = width_for(max_u(IV_NORM, IV_HOT));

    logic [W-1:0] cnt_q;
    logic [W-1:0] reload;

    always_comb begin
        reload = hot ? W'(IV_HOT - 1) : W'(IV_NORM - 1);
    end

    assign tick = run && !restart && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= W'(IV_NORM - 1);
        end else if (restart) begin
            cnt_q <= reload;
        end else if (run) begin
            if (cnt_q == '0) cnt_q <= reload;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // R3: expiry always reloads with one of the two configured intervals
    p_reload_value_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> ((cnt_q == W'(IV_NORM - 1)) || (cnt_q == W'(IV_HOT - 1))));

    // R7: a stopped timer holds its count
    p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/refsched_owe_ctr.sv
module refsched_owe_ctr
    import refsched_pkg::*;
#(
    parameter int unsigned MAX_PEND = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  owe_evt_t evt,
    output logic [width_for(MAX_PEND)-1:0] owed,
    output logic     full
);
    localparam int unsigned PW = width_for(MAX_PEND);

    logic [PW-1:0] owed_q;

    assign owed = owed_q;
    assign full = (owed_q == PW'(MAX_PEND));

    always_ff @(posedge clk) begin
        if (rst || evt.clear) begin
            owed_q <= '0;
        end else begin
            unique case ({evt.tick, evt.grant})
                2'b10:   if (!full) owed_q <= owed_q + 1'b1;
                2'b01:   owed_q <= owed_q - 1'b1;
                default: owed_q <= owed_q;
            endcase
        end
    end

    // R5: never above the postponement limit
    p_owed_bound_r5: assert property (@(posedge clk) disable iff (rst)
        owed_q <= PW'(MAX_PEND));

    // R4: a lone grant takes exactly one owed refresh away
    p_grant_dec_r4: assert property (@(posedge clk) disable iff (rst)
        (evt.grant && !evt.tick && !evt.clear) |=> (owed_q == $past(owed_q) - 1'b1));

    // R4: grant plus expiry in one cycle leaves the count alone
    p_grant_tick_r4: assert property (@(posedge clk) disable iff (rst)
        (evt.grant && evt.tick && !evt.clear) |=> $stable(owed_q));

endmodule

// File: rtl/refsched_hold_ctr.sv
module refsched_hold_ctr
    import refsched_pkg::*;
#(
    parameter int unsigned SPAN = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active
);
    localparam int unsigned HW = width_for(SPAN);

    logic [HW-1:0] cnt_q;

    assign active = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (start)  cnt_q <= HW'(SPAN);
        else if (active) cnt_q <= cnt_q - 1'b1;
    end

    // R6, R8: a started window runs to its end without reloading early
    p_hold_down_r6: assert property (@(posedge clk) disable iff (rst)
        (active && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
    import refsched_pkg::*;
#(
    parameter int unsigned TREFI_NORM = 6240,
    parameter int unsigned TREFI_HOT  = 3120,
    parameter int unsigned TRFC       = 128,
    parameter int unsigned XS_EXTRA   = 8,
    parameter int unsigned MAX_PEND   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic temp_hot,
    input  logic arb_gnt,
    input  logic sr_enter,
    input  logic sr_exit,
    output logic ref_req,
    output logic ref_urgent,
    output logic rank_busy
);
    localparam int unsigned TXS = max_u(5, TRFC + XS_EXTRA);
    localparam int unsigned PW  = width_for(MAX_PEND);

    rank_mode_e    mode_q;
    logic          tick;
    logic          grant_now;
    logic          rfc_act;
    logic          xs_act;
    logic          enter_ok;
    logic          exit_ok;
    logic [PW-1:0] owed;
    logic          owed_full;
    owe_evt_t      evt;

    assign ref_req    = (mode_q == RK_RUN) && (owed != '0) && !rfc_act && !xs_act;
    assign grant_now  = ref_req && arb_gnt;
    assign rank_busy  = grant_now || rfc_act || xs_act || (mode_q == RK_SELF);
    assign ref_urgent = owed_full;
    assign enter_ok   = sr_enter && (mode_q == RK_RUN) && !rank_busy;
    assign exit_ok    = sr_exit && (mode_q == RK_SELF);

    always_comb begin
        evt.clear = enter_ok;
        evt.tick  = tick;
        evt.grant = grant_now;
    end

    always_ff @(posedge clk) begin
        if (rst)           mode_q <= RK_RUN;
        else if (enter_ok) mode_q <= RK_SELF;
        else if (exit_ok)  mode_q <= RK_RUN;
    end

    refsched_interval_timer #(
        .IV_NORM (TREFI_NORM),
        .IV_HOT  (TREFI_HOT)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (mode_q == RK_RUN),
        .restart (exit_ok),
        .hot     (temp_hot),
        .tick    (tick)
    );

    refsched_owe_ctr #(
        .MAX_PEND (MAX_PEND)
    ) u_owe (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .owed  (owed),
        .full  (owed_full)
    );

    // grant cycle plus TRFC-1 following cycles
    refsched_hold_ctr #(
        .SPAN (TRFC - 1)
    ) u_rfc_hold (
        .clk    (clk),
        .rst    (rst),
        .start  (grant_now),
        .active (rfc_act)
    );

    refsched_hold_ctr #(
        .SPAN (TXS)
    ) u_xs_hold (
        .clk    (clk),
        .rst    (rst),
        .start  (exit_ok),
        .active (xs_act)
    );

    // R6: the cycle after a grant is still blocked
    p_busy_after_grant_r6: assert property (@(posedge clk) disable iff (rst)
        (grant_now && (TRFC > 1)) |=> (rank_busy && !ref_req));

    // R7: nothing is owed and nothing is requested during self refresh
    p_sr_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == RK_SELF) |-> ((owed == '0) && !ref_req));

    // R8: the first cycle after leaving self refresh is blocked
    p_exit_hold_r8: assert property (@(posedge clk) disable iff (rst)
        exit_ok |=> (rank_busy && (mode_q == RK_RUN)));

    // R5: urgency only with refreshes owed in normal operation
    p_urgent_owed_r5: assert property (@(posedge clk) disable iff (rst)
        ref_urgent |-> (owed != '0));

endmodule

// File: tb/refresh_scheduler_test.sv
module refresh_scheduler_test;

    localparam int IVN  = 64;
    localparam int IVH  = 32;
    localparam int RFC  = 6;
    localparam int XEX  = 3;
    localparam int MAXP = 8;

    logic clk = 1'b0;
    logic rst, temp_hot, arb_gnt, sr_enter, sr_exit;
    logic ref_req, ref_urgent, rank_busy;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // requirement-level model
    int  m_cnt, m_pend, m_rfc, m_xs;
    bit  m_self;
    logic s_req, s_urg, s_busy;

    always #5 clk = ~clk;

    refresh_scheduler #(
        .TREFI_NORM (IVN),
        .TREFI_HOT  (IVH),
        .TRFC       (RFC),
        .XS_EXTRA   (XEX),
        .MAX_PEND   (MAXP)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .temp_hot   (temp_hot),
        .arb_gnt    (arb_gnt),
        .sr_enter   (sr_enter),
        .sr_exit    (sr_exit),
        .ref_req    (ref_req),
        .ref_urgent (ref_urgent),
        .rank_busy  (rank_busy)
    );

    function automatic int xs_cycles();
        return (RFC + XEX > 5) ? RFC + XEX : 5;
    endfunction

    function automatic int iv_of(bit h);
        return h ? IVH : IVN;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = IVN - 1; m_pend = 0; m_rfc = 0; m_xs = 0; m_self = 0;
    endtask

    // one cycle: drive, sample, compare, advance the model
    task automatic cyc(bit h, bit g, bit en, bit ex);
        bit e_req, e_grant, e_busy, e_urg, e_tick, e_en, e_ex;
        temp_hot = h; arb_gnt = g; sr_enter = en; sr_exit = ex;
        #1;
        e_req   = !m_self && m_pend != 0 && m_rfc == 0 && m_xs == 0;
        e_grant = e_req && g;
        e_busy  = e_grant || m_rfc != 0 || m_xs != 0 || m_self;
        e_urg   = (m_pend == MAXP);
        e_tick  = !m_self && m_cnt == 0;
        e_en    = en && !m_self && !e_busy;
        e_ex    = ex && m_self;
        s_req = ref_req; s_urg = ref_urgent; s_busy = rank_busy;
        if (!rst) begin
            chk("R4 ref_req", ref_req, e_req);
            chk("R6 rank_busy", rank_busy, e_busy);
            chk("R5 ref_urgent", ref_urgent, e_urg);
        end
        if (rst) begin
            model_reset();
        end else begin
            if (e_ex) m_cnt = iv_of(h) - 1;
            else if (!m_self) m_cnt = (m_cnt == 0) ? iv_of(h) - 1 : m_cnt - 1;
            if (e_en) m_pend = 0;
            else if (e_tick && !e_grant && m_pend < MAXP) m_pend++;
            else if (e_grant && !e_tick) m_pend--;
            if (e_grant) m_rfc = RFC - 1; else if (m_rfc > 0) m_rfc--;
            if (e_ex) m_xs = xs_cycles(); else if (m_xs > 0) m_xs--;
            if (e_en) m_self = 1; else if (e_ex) m_self = 0;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog (R1..R8 run) actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h5eed_1234));
        rst = 1; temp_hot = 0; arb_gnt = 0; sr_enter = 0; sr_exit = 0;
        model_reset();
        @(negedge clk);
        repeat (3) cyc(0, 0, 0, 0);
        rst = 0;

        // R1: outputs quiet after reset
        cyc(0, 0, 0, 0);
        chk("R1 req after reset", s_req, 1'b0);
        chk("R1 busy after reset", s_busy, 1'b0);
        chk("R1 urgent after reset", s_urg, 1'b0);

        // R2: first request at cycle IVN
        n = 1;
        while (!s_req && n < 4 * IVN) begin cyc(0, 0, 0, 0); n++; end
        total++;
        if (n - 1 != IVN) begin
            bad++; $display("FAIL R2 first request cycle actual=%0d expected=%0d", n - 1, IVN);
        end

        // R6: grant -> busy for exactly RFC cycles
        cyc(0, 1, 0, 0);
        chk("R6 busy on grant", s_busy, 1'b1);
        for (int i = 1; i < RFC; i++) begin
            cyc(0, 0, 0, 0);
            chk("R6 busy window", s_busy, 1'b1);
            chk("R6 no req in window", s_req, 1'b0);
        end
        cyc(0, 0, 0, 0);
        chk("R6 busy released", s_busy, 1'b0);

        // R3: raise temperature mid-interval; the running interval stays normal
        for (int i = 0; i < 3 * IVN; i++) begin
            cyc(i > 10, s_req, 0, 0);
        end

        // R5: starve the arbiter well past saturation while hot
        for (int i = 0; i < (MAXP + 2) * IVH; i++) cyc(1, 0, 0, 0);
        chk("R5 urgent at limit", s_urg, 1'b1);
        // R4: drain with grants whenever allowed
        for (int i = 0; i < MAXP * (RFC + 1) + 4; i++) cyc(1, s_req, 0, 0);
        chk("R5 urgent cleared", s_urg, 1'b0);

        // R7: entry while busy is ignored, then a real entry
        while (!s_req) cyc(0, 0, 0, 0);
        cyc(0, 1, 0, 0);
        cyc(0, 0, 1, 0);
        for (int i = 0; i < RFC; i++) cyc(0, 0, 0, 0);
        chk("R7 ignored entry leaves rank free", s_busy, 1'b0);
        cyc(0, 0, 1, 0);
        for (int i = 0; i < 3 * IVN; i++) begin
            cyc(0, 1, 1, 0);
            if (i % 40 == 0) begin
                chk("R7 no req in self refresh", s_req, 1'b0);
                chk("R7 busy in self refresh", s_busy, 1'b1);
            end
        end

        // R8: exit holds busy for xs_cycles, then a fresh interval
        cyc(0, 0, 0, 1);
        n = 0;
        cyc(0, 0, 0, 0);
        while (s_busy && n < 100) begin n++; cyc(0, 0, 0, 0); end
        total++;
        if (n != xs_cycles()) begin
            bad++; $display("FAIL R8 exit hold actual=%0d expected=%0d", n, xs_cycles());
        end
        cyc(0, 0, 0, 1);
        chk("R8 stray exit has no effect", s_busy, 1'b0);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            bit h, g, en, ex;
            h  = ($urandom % 500) == 0 ? !temp_hot : temp_hot;
            g  = ($urandom % 4) == 0;
            en = ($urandom % 300) == 0;
            ex = ($urandom % 40) == 0;
            cyc(h, g, en, ex);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule